// File: doc/BRIEF.md
# Up/Down Gain Code Stepper

This block keeps a 6-bit gain code and moves it with a two-wire stepping interface: a step clock and a direction line. Every full pulse of the step clock (low, high, low) is one command. The direction line is sampled on the rising edge of the pulse and again on the falling edge. When both samples agree, the code moves by one step. A high direction line means more gain, so the code goes down. A low direction line means less gain, so the code goes up. When the two samples disagree, the pulse is a reset and the code returns to 63, the lowest gain.

The step size comes from a two-bit select input. It gives 1, 2, 4 or 8 code units, which at 0.5 dB per unit is 0.5, 1, 2 or 4 dB. The code stops at 0 and at 63 and never wraps. The step clock and direction line may arrive with no timing relation to the system clock. Each passes through a synchronizer before its edges are found in the system-clock domain.

Top module: `gain_stepper`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, the code becomes 63 (binary 111111, lowest gain). It reads 63 after reset is released and before any step pulse arrives.
- R2: A pulse whose direction line is 1 at both its rising and its falling edge lowers the code by the selected step size.
- R3: A pulse whose direction line is 0 at both edges raises the code by the selected step size.
- R4: The step size is 1 << `step_sel_i`: select 0 gives 1 unit, 1 gives 2, 2 gives 4 and 3 gives 8. The select value is read when the falling edge of the pulse is handled.
- R5: A gain-raising step that would take the code below 0 leaves it at 0.
- R6: A gain-lowering step that would take the code above 63 leaves it at 63.
- R7: A pulse whose direction line differs between its rising and falling edges sets the code to 63. This holds for both orders, 1 then 0 and 0 then 1, and for any starting code.
- R8: The code changes only on the falling edge of a step pulse. A rising edge alone does not move it, and neither does toggling the direction line while the step clock holds still.
- R9: The code changes at the third rising edge of `clk_i` that samples the step clock low after a falling edge. At the second such edge it still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the step clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_clk_i | input | 1 | Asynchronous step clock; one pulse is one command |
| step_dat_i | input | 1 | Asynchronous direction line; 1 raises gain, 0 lowers it |
| step_sel_i | input | 2 | Step size select, 1 << value code units |
| gain_code_o | output | 6 | Registered gain code; 0 is maximum gain, 63 is minimum |

## Verification
Pulses with a steady high direction line are run at all four select values. These tell apart the four step sizes and show that the code moves down. Steady low pulses show the opposite direction. Runs of pulses are driven into both ends of the range, including steps that overshoot the end by less than a full step, so clamping is told apart from wrapping.

Pulses whose direction line flips between the edges, in both orders, are started from codes far from 63 so that a reset cannot be mistaken for a step. Rising edges with no falling edge, and toggling of the direction line while the step clock holds still, show that only the falling edge acts. A single pulse sampled at the cycles on either side of the update pins down the latency.

// File: rtl/gstep_pkg.sv
package gstep_pkg;

  // width of the step-size select
  localparam int unsigned SEL_W = 2;

  // step size in code units: 1 << select
  function automatic int unsigned step_units(input logic [SEL_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // decoded meaning of one complete step-clock pulse
  typedef enum logic [1:0] {
    PULSE_NONE  = 2'b00,
    PULSE_STEP  = 2'b01,
    PULSE_RESET = 2'b10
  } pulse_kind_e;

endpackage

// File: rtl/gstep_sync.sv
// Multi-stage synchronizer, one chain per bit.
module gstep_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        chain_q[b] <= '0;
      end else if (STAGES == 1) begin
        chain_q[b] <= async_i[b];
      end else begin
        chain_q[b] <= {chain_q[b][STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain_q[b][STAGES-1];
  end

endmodule

// File: rtl/gstep_pulse_decode.sv
// Finds the edges of the synchronized step clock, captures the direction
// at the rising edge and classifies the pulse at the falling edge.
module gstep_pulse_decode
  import gstep_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        sclk_i,
  input  logic        sdat_i,
  output pulse_kind_e kind_o,
  output logic        dir_up_o
);

  logic sclk_prev_q;
  logic dat_at_rise_q;
  logic rise_w, fall_w;

  assign rise_w = sclk_i & ~sclk_prev_q;
  assign fall_w = ~sclk_i & sclk_prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sclk_prev_q   <= 1'b0;
      dat_at_rise_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_i;
      if (rise_w) dat_at_rise_q <= sdat_i;
    end
  end

  always_comb begin
    kind_o = PULSE_NONE;
    if (fall_w) begin
      kind_o = (dat_at_rise_q == sdat_i) ? PULSE_STEP : PULSE_RESET;
    end
  end

  assign dir_up_o = dat_at_rise_q;

  // one decision per falling edge: never two in consecutive cycles
  p_single_decision_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_o != PULSE_NONE) |=> (kind_o == PULSE_NONE));

  // a decision cycle is always followed by a low step clock sample
  p_decision_on_low_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_o != PULSE_NONE) |=> !sclk_prev_q);

endmodule

// File: rtl/gstep_code_reg.sv
// Holds the gain code and applies saturated steps or the reset value.
module gstep_code_reg
  import gstep_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  pulse_kind_e       kind_i,
  input  logic              dir_up_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W:0]   MAX_EXT  = {1'b0, {CODE_W{1'b1}}};
  localparam logic [CODE_W-1:0] CODE_MIN_GAIN = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W:0]   step_w, ext_w, sum_w, diff_w;

  always_comb begin
    step_w = (CODE_W+1)'(step_units(sel_i));
    ext_w  = {1'b0, code_q};
    sum_w  = ext_w + step_w;
    diff_w = ext_w - step_w;
    code_d = code_q;
    case (kind_i)
      PULSE_RESET: code_d = CODE_MIN_GAIN;
      PULSE_STEP: begin
        if (dir_up_i) begin
          code_d = (ext_w < step_w) ? '0 : diff_w[CODE_W-1:0];
        end else begin
          code_d = (sum_w > MAX_EXT) ? CODE_MIN_GAIN : sum_w[CODE_W-1:0];
        end
      end
      default: code_d = code_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) code_q <= CODE_MIN_GAIN;
    else       code_q <= code_d;
  end

  assign code_o = code_q;

  p_reset_value_r1: assert property (@(posedge clk_i)
    rst_i |=> (code_q == CODE_MIN_GAIN));

  p_up_not_rising_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == PULSE_STEP && dir_up_i) |=> (code_q <= $past(code_q)));

  p_down_not_falling_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == PULSE_STEP && !dir_up_i) |=> (code_q >= $past(code_q)));

  p_floor_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == PULSE_STEP && dir_up_i && ({1'b0, code_q} <= step_w))
      |=> (code_q == '0));

  p_ceiling_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == PULSE_STEP && !dir_up_i && (sum_w >= MAX_EXT))
      |=> (code_q == CODE_MIN_GAIN));

  p_pattern_reset_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == PULSE_RESET) |=> (code_q == CODE_MIN_GAIN));

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == PULSE_NONE) |=> $stable(code_q));

endmodule

// File: rtl/gain_stepper.sv
module gain_stepper
  import gstep_pkg::*;
#(
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              step_clk_i,
  input  logic              step_dat_i,
  input  logic [SEL_W-1:0]  step_sel_i,
  output logic [CODE_W-1:0] gain_code_o
);

  logic [1:0]  sync_w;
  pulse_kind_e kind_w;
  logic        dir_up_w;

  gstep_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i({step_dat_i, step_clk_i}),
    .sync_o (sync_w)
  );

  gstep_pulse_decode i_decode (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sclk_i  (sync_w[0]),
    .sdat_i  (sync_w[1]),
    .kind_o  (kind_w),
    .dir_up_o(dir_up_w)
  );

  gstep_code_reg #(
    .CODE_W(CODE_W)
  ) i_code (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .kind_i  (kind_w),
    .dir_up_i(dir_up_w),
    .sel_i   (step_sel_i),
    .code_o  (gain_code_o)
  );

endmodule

// File: tb/test_gain_stepper.sv
module test_gain_stepper;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       step_clk_i = 1'b0;
  logic       step_dat_i = 1'b0;
  logic [1:0] step_sel_i = 2'd0;
  logic [5:0] gain_code_o;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_code = 63;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gain_stepper i_gain_stepper (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_clk_i (step_clk_i),
    .step_dat_i (step_dat_i),
    .step_sel_i (step_sel_i),
    .gain_code_o(gain_code_o)
  );

  task automatic check(input string req, input int expv);
    n_checks++;
    if (int'(gain_code_o) != expv) begin
      n_fail++;
      $display("FAIL %s: gain_code_o=%0d expected %0d", req, gain_code_o, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // model of one step from the requirements
  function automatic int model_step(input int c, input bit up, input int sel);
    int s;
    s = 1 << sel;
    if (up) return (c - s < 0) ? 0 : c - s;
    return (c + s > 63) ? 63 : c + s;
  endfunction

  // full pulse: direction d_rise held over the rising edge, d_fall over the falling
  task automatic pulse(input bit d_rise, input bit d_fall);
    step_dat_i = d_rise; idle(4);
    step_clk_i = 1'b1;   idle(6);
    step_dat_i = d_fall; idle(4);
    step_clk_i = 1'b0;   idle(6);
  endtask

  task automatic t_reset_state;
    rst_i = 1'b1; idle(3);
    rst_i = 1'b0; idle(2);
    exp_code = 63;
    check("R1 reset state", exp_code);
  endtask

  task automatic t_sizes_up;
    for (int s = 0; s < 4; s++) begin
      step_sel_i = 2'(s);
      pulse(1'b1, 1'b1);
      exp_code = model_step(exp_code, 1'b1, s);
      check($sformatf("R2 R4 up step sel=%0d", s), exp_code);
    end
  endtask

  task automatic t_down;
    step_sel_i = 2'd1;
    pulse(1'b0, 1'b0);
    exp_code = model_step(exp_code, 1'b0, 1);
    check("R3 down step sel=1", exp_code);
    step_sel_i = 2'd2;
    pulse(1'b0, 1'b0);
    exp_code = model_step(exp_code, 1'b0, 2);
    check("R3 R4 down step sel=2", exp_code);
  endtask

  task automatic t_only_fall;
    step_dat_i = 1'b1; idle(4);
    step_clk_i = 1'b1; idle(8);
    check("R8 rising edge alone", exp_code);
    step_dat_i = 1'b0; idle(3);
    step_dat_i = 1'b1; idle(5);
    check("R8 data toggle while clock high", exp_code);
    step_sel_i = 2'd0;
    step_clk_i = 1'b0; idle(6);
    exp_code = model_step(exp_code, 1'b1, 0);
    check("R8 falling edge acts", exp_code);
    for (int i = 0; i < 4; i++) begin
      step_dat_i = ~step_dat_i; idle(3);
    end
    check("R8 data toggle while clock low", exp_code);
  endtask

  task automatic t_floor;
    step_sel_i = 2'd3;
    for (int i = 0; i < 9; i++) begin
      pulse(1'b1, 1'b1);
      exp_code = model_step(exp_code, 1'b1, 3);
    end
    check("R5 floor after run", 0);
    step_sel_i = 2'd1;
    pulse(1'b0, 1'b0);
    exp_code = model_step(exp_code, 1'b0, 1);
    check("R3 leave floor", 2);
    step_sel_i = 2'd3;
    pulse(1'b1, 1'b1);
    exp_code = model_step(exp_code, 1'b1, 3);
    check("R5 partial overshoot clamps", 0);
  endtask

  task automatic t_ceiling;
    step_sel_i = 2'd3;
    for (int i = 0; i < 7; i++) begin
      pulse(1'b0, 1'b0);
      exp_code = model_step(exp_code, 1'b0, 3);
    end
    check("R3 run to 56", 56);
    step_sel_i = 2'd2;
    pulse(1'b0, 1'b0);
    exp_code = model_step(exp_code, 1'b0, 2);
    check("R3 step to 60", 60);
    step_sel_i = 2'd3;
    pulse(1'b0, 1'b0);
    exp_code = model_step(exp_code, 1'b0, 3);
    check("R6 partial overshoot clamps", 63);
    pulse(1'b0, 1'b0);
    check("R6 stays at ceiling", 63);
  endtask

  task automatic t_pattern_reset;
    step_sel_i = 2'd3;
    pulse(1'b1, 1'b1); pulse(1'b1, 1'b1);
    exp_code = 47;
    check("R2 setup for pattern reset", exp_code);
    pulse(1'b1, 1'b0);
    exp_code = 63;
    check("R7 pattern 1 then 0", exp_code);
    pulse(1'b1, 1'b1); pulse(1'b1, 1'b1); pulse(1'b1, 1'b1);
    exp_code = 39;
    check("R2 setup second pattern", exp_code);
    pulse(1'b0, 1'b1);
    exp_code = 63;
    check("R7 pattern 0 then 1", exp_code);
  endtask

  task automatic t_latency;
    step_sel_i = 2'd2;
    step_dat_i = 1'b1; idle(4);
    step_clk_i = 1'b1; idle(6);
    step_clk_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    check("R9 unchanged after two edges", exp_code);
    @(posedge clk_i); @(negedge clk_i);
    exp_code = model_step(exp_code, 1'b1, 2);
    check("R9 updated at third edge", exp_code);
    idle(4);
  endtask

  task automatic t_midrun_reset;
    step_sel_i = 2'd3;
    pulse(1'b1, 1'b1);
    exp_code = model_step(exp_code, 1'b1, 3);
    rst_i = 1'b1; idle(1);
    rst_i = 1'b0; idle(1);
    exp_code = 63;
    check("R1 reset during operation", exp_code);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset_state();
    t_sizes_up();
    t_down();
    t_only_fall();
    t_floor();
    t_ceiling();
    t_pattern_reset();
    t_latency();
    t_midrun_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule